// File: doc/BRIEF.md
# Alternating Two-Buffer Receive DMA

This block takes a stream of received bytes, parks them in a four-entry FIFO and copies them into memory through one of two receive buffers, A and B, that take turns. Software arms a buffer with a start address and a byte length and pulses its load input. The engine writes into the active buffer at its start address plus a running byte offset. When the offset reaches the length, the engine releases that buffer and moves on to the other one if it is armed.

Bytes that arrive while no buffer is armed stay in the FIFO. Once the FIFO is full, further bytes are lost and the FIFO records the loss. That record is charged to whichever buffer next drains the FIFO. A read-only status word shows, per buffer, the receive-active and overrun flags. It also carries two transmit-active bits that come in from a neighbouring transmit engine.

The byte input carries a valid only. The source is never stalled: each valid cycle offers one byte, and a byte offered while the FIFO holds four entries is dropped and marked. The memory write port is a one-cycle strobe with address and data and has no back-pressure.

Top module: `rx_pingpong_dma`

## Requirements
- R1: At most one buffer is active at any time. An armed buffer becomes active on the edge after it is seen armed, provided no buffer is active then. Status bit 0 reflects A active and bit 1 reflects B active.
- R2: A byte offered on a valid cycle enters the FIFO if fewer than 4 entries are held. While a buffer is active, bytes leave the FIFO in arrival order, one per cycle. Each leaving byte produces one write strobe with address = buffer start + byte offset.
- R3: Each buffer has a 13-bit byte offset that starts at 0 and steps by one per byte written. The byte that brings the offset to the length wraps the offset to 0 and clears that buffer's armed and active state.
- R4: When the active buffer fills and the other buffer is armed, the other buffer becomes active one cycle later and writing continues there.
- R5: When both buffers are armed and neither is active, the engine picks the buffer that was not filled most recently. After reset it picks A.
- R6: A byte offered while the FIFO holds 4 entries is dropped. The next byte that leaves the FIFO sets the overrun flag of the buffer that writes it: status bit 4 for A, bit 5 for B.
- R7: Loading a buffer that is not active replaces its start and length and clears its overrun flag. A load aimed at the active buffer is ignored.
- R8: Status bits 2 and 3 follow the transmit-active inputs for A and B. Bits 15 down to 6 read 0.
- R9: A DMA reset pulse clears both offsets and all armed, active and overrun flags. It also empties the FIFO and its loss record and points the preference back to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_reset | input | 1 | Synchronous receive DMA reset pulse |
| in_valid | input | 1 | Received byte present this cycle |
| in_data | input | 8 | Received byte |
| load_a | input | 1 | Arm buffer A with start_a / len_a |
| start_a | input | 16 | Buffer A start address |
| len_a | input | 13 | Buffer A length in bytes (1 to 8191) |
| load_b | input | 1 | Arm buffer B with start_b / len_b |
| start_b | input | 16 | Buffer B start address |
| len_b | input | 13 | Buffer B length in bytes (1 to 8191) |
| tx_act_a | input | 1 | Transmit buffer A active, shown in status |
| tx_act_b | input | 1 | Transmit buffer B active, shown in status |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory write byte address |
| wr_data | output | 8 | Memory write data |
| offset_a | output | 13 | Buffer A byte offset |
| offset_b | output | 13 | Buffer B byte offset |
| status | output | 16 | Read-only status word |

## Verification
A byte offered on edge e is written out on edge e+1 if a buffer is already active. Its strobe, and the matching offset step, are visible after that edge. A load pulse arms its buffer on the edge that samples it, and the buffer goes active one edge later. The transmit bits in status follow their inputs in the same cycle. A scoreboard queue receives the expected address and data of every write as each byte is driven, and a monitor compares strobes at falling edges. Status words and offsets are sampled only after enough idle cycles for these latencies to settle, so no check depends on an exact edge race.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int STAT_W      = 16;
  localparam int ST_RXACT_A  = 0;
  localparam int ST_RXACT_B  = 1;
  localparam int ST_TXACT_A  = 2;
  localparam int ST_TXACT_B  = 3;
  localparam int ST_OVF_A    = 4;
  localparam int ST_OVF_B    = 5;
  localparam int ST_USED     = 6;
endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] head,
  output logic         head_ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          lost;
  logic          full, push, take;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = in_valid && !full;
  assign take  = pop && !empty;
  assign head  = mem[rp];
  assign head_ovf = lost;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; lost <= 1'b0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0; lost <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (take) rp <= nxt(rp);
      if (push && !take)      count <= count + 1'b1;
      else if (take && !push) count <= count - 1'b1;
      if (take) lost <= 1'b0;
      if (in_valid && full) lost <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !take && !clr) |=> (count == $past(count)));
  // R9
  fifo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !lost));
endmodule

// File: rtl/rxdma_slot.sv
module rxdma_slot #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [ADDR_W-1:0] start,
  input  logic [CNT_W-1:0]  len,
  input  logic              activate,
  input  logic              wr,
  input  logic              wr_ovf,
  output logic              armed,
  output logic              active,
  output logic              ovf,
  output logic              last,
  output logic [CNT_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] start_r;
  logic [CNT_W-1:0]  len_r;
  logic              take_load;

  assign take_load = load && !active;
  assign last      = (offset == CNT_W'(len_r - 1'b1));
  assign addr      = start_r + ADDR_W'(offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_r <= '0; len_r <= '0; offset <= '0;
      armed <= 1'b0; active <= 1'b0; ovf <= 1'b0;
    end else if (clr) begin
      offset <= '0; armed <= 1'b0; active <= 1'b0; ovf <= 1'b0;
    end else begin
      if (take_load) begin
        start_r <= start;
        len_r   <= len;
        armed   <= 1'b1;
        ovf     <= 1'b0;
      end
      if (activate) active <= 1'b1;
      if (wr) begin
        if (wr_ovf) ovf <= 1'b1;
        if (last) begin
          offset <= '0;
          armed  <= 1'b0;
          active <= 1'b0;
        end else begin
          offset <= offset + 1'b1;
        end
      end
    end
  end

  // R7
  load_clears_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_load && !clr) |=> (!ovf && armed));
  // R3
  wrap_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && last && !clr) |=> (offset == '0 && !active && !armed));
  // R7
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && active && !wr && !clr) |=> $stable(offset) && active);
endmodule

// File: rtl/rx_pingpong_dma.sv
module rx_pingpong_dma
  import rxdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 13,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_reset,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              load_a,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [CNT_W-1:0]  len_a,
  input  logic              load_b,
  input  logic [ADDR_W-1:0] start_b,
  input  logic [CNT_W-1:0]  len_b,
  input  logic              tx_act_a,
  input  logic              tx_act_b,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [CNT_W-1:0]  offset_a,
  output logic [CNT_W-1:0]  offset_b,
  output logic [STAT_W-1:0] status
);
  localparam int NBUF = 2;

  logic              fifo_empty, head_ovf, pop, idle, prefer_a, fill_done;
  logic [7:0]        head;
  logic [NBUF-1:0]   armed, active, ovf, last, go, ld;
  logic [ADDR_W-1:0] st  [NBUF];
  logic [CNT_W-1:0]  ln  [NBUF];
  logic [CNT_W-1:0]  off [NBUF];
  logic [ADDR_W-1:0] adr [NBUF];

  assign ld    = {load_b, load_a};
  assign st[0] = start_a;  assign st[1] = start_b;
  assign ln[0] = len_a;    assign ln[1] = len_b;

  assign idle  = (active == '0);
  assign go[0] = idle && armed[0] && (!armed[1] || prefer_a);
  assign go[1] = idle && armed[1] && (!armed[0] || !prefer_a);
  assign pop   = !fifo_empty && !idle && !dma_reset;
  assign fill_done = pop && |(active & last);

  rxdma_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(dma_reset),
    .in_valid(in_valid), .in_data(in_data), .pop(pop),
    .empty(fifo_empty), .head(head), .head_ovf(head_ovf)
  );

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    rxdma_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(dma_reset),
      .load(ld[i]), .start(st[i]), .len(ln[i]),
      .activate(go[i]), .wr(pop && active[i]), .wr_ovf(head_ovf),
      .armed(armed[i]), .active(active[i]), .ovf(ovf[i]),
      .last(last[i]), .offset(off[i]), .addr(adr[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefer_a <= 1'b1;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= pop;
      if (pop) begin
        wr_addr <= active[1] ? adr[1] : adr[0];
        wr_data <= head;
      end
      if (dma_reset)      prefer_a <= 1'b1;
      else if (fill_done) prefer_a <= active[1];
    end
  end

  assign offset_a = off[0];
  assign offset_b = off[1];

  always_comb begin
    status = '0;
    status[ST_RXACT_A] = active[0];
    status[ST_RXACT_B] = active[1];
    status[ST_TXACT_A] = tx_act_a;
    status[ST_TXACT_B] = tx_act_b;
    status[ST_OVF_A]   = ovf[0];
    status[ST_OVF_B]   = ovf[1];
  end

  // R1
  single_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(active[0] && active[1]));
  // R2
  write_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(active != '0));
  // R8
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[STAT_W-1:ST_USED] == '0);
  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_reset |=> (!wr_en && active == '0 && ovf == '0 && armed == '0));
endmodule

// File: tb/rx_pingpong_dma_test.sv
module rx_pingpong_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_reset = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        load_a = 1'b0, load_b = 1'b0;
  logic [15:0] start_a = '0, start_b = '0;
  logic [12:0] len_a = '0, len_b = '0;
  logic        tx_act_a = 1'b0, tx_act_b = 1'b0;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [12:0] offset_a, offset_b;
  logic [15:0] status;

  int compared = 0;
  int mismatched = 0;
  logic [23:0] expq [$];

  always #4 clk = ~clk;

  rx_pingpong_dma uut (
    .clk(clk), .rst_n(rst_n), .dma_reset(dma_reset),
    .in_valid(in_valid), .in_data(in_data),
    .load_a(load_a), .start_a(start_a), .len_a(len_a),
    .load_b(load_b), .start_b(start_b), .len_b(len_b),
    .tx_act_a(tx_act_a), .tx_act_b(tx_act_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .offset_a(offset_a), .offset_b(offset_b), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare every write strobe with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (expq.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R2: unexpected write actual %h/%h expected none",
                 wr_addr, wr_data);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        check("R2 write", {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit expect_wr,
                      input logic [15:0] a);
    @(negedge clk);
    if (expect_wr) expq.push_back({a, d});
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(input bit sel_a, input bit sel_b,
                      input logic [15:0] sa, input logic [12:0] la,
                      input logic [15:0] sb, input logic [12:0] lb);
    @(negedge clk);
    load_a = sel_a; start_a = sa; len_a = la;
    load_b = sel_b; start_b = sb; len_b = lb;
    @(negedge clk);
    load_a = 1'b0; load_b = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    dma_reset = 1'b1;
    @(negedge clk);
    dma_reset = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R9 reset state
    check("R9 reset status", status, 0);
    check("R9 reset offset_a", offset_a, 0);
    check("R9 reset wr_en", wr_en, 0);

    // both armed at once after reset: A first (R5), then B (R4)
    load(1, 1, 16'h0100, 13'd4, 16'h0200, 13'd3);
    idle(3);
    check("R1 A active", status, 16'h0001);
    send(8'h11, 1, 16'h0100);
    send(8'h22, 1, 16'h0101);
    idle(3);
    check("R3 offset step", offset_a, 2);
    send(8'h33, 1, 16'h0102);
    send(8'h44, 1, 16'h0103);
    idle(3);
    check("R4 B took over", status, 16'h0002);
    check("R3 offset_a wrapped", offset_a, 0);
    send(8'h55, 1, 16'h0200);
    send(8'h66, 1, 16'h0201);
    send(8'h77, 1, 16'h0202);
    idle(5);
    check("R3 all released", status, 0);
    check("R3 offset_b wrapped", offset_b, 0);

    // overrun with nothing armed: 6 bytes back-to-back, last 2 lost
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      in_valid = 1'b1; in_data = 8'hA0 + 8'(k);
      if (k < 4) expq.push_back({16'h0300 + 16'(k), 8'hA0 + 8'(k)});
      @(negedge clk);
    end
    in_valid = 1'b0;
    idle(3);
    check("R6 no charge while idle", status, 0);
    load(1, 0, 16'h0300, 13'd8, 16'h0, 13'd0);
    idle(8);
    check("R6 overrun charged to A", status, 16'h0011);
    check("R2 held bytes drained", offset_a, 4);
    for (int k = 4; k < 8; k++) send(8'hB0 + 8'(k), 1, 16'h0300 + 16'(k));
    idle(5);
    check("R6 flag outlives unload", status, 16'h0010);

    // A filled last: both armed together -> B first (R5), A flag cleared (R7)
    load(1, 1, 16'h0500, 13'd1, 16'h0400, 13'd2);
    idle(3);
    check("R5 R7 B first, ovf A cleared", status, 16'h0002);
    send(8'hC1, 1, 16'h0400);
    send(8'hC2, 1, 16'h0401);
    send(8'hC3, 1, 16'h0500);
    idle(5);
    check("R4 chain done", status, 0);

    // load to active buffer is ignored (R7)
    load(1, 0, 16'h0600, 13'd2, 16'h0, 13'd0);
    idle(3);
    load(1, 0, 16'h0700, 13'd5, 16'h0, 13'd0);
    send(8'hD1, 1, 16'h0600);
    send(8'hD2, 1, 16'h0601);
    idle(5);
    check("R7 busy load ignored", status, 0);

    // transmit bits pass through (R8)
    @(negedge clk); tx_act_a = 1'b1;
    @(negedge clk);
    check("R8 tx A", status, 16'h0004);
    tx_act_b = 1'b1;
    @(negedge clk);
    check("R8 tx both", status, 16'h000C);
    tx_act_a = 1'b0; tx_act_b = 1'b0;

    // DMA reset mid-buffer and with a full FIFO (R9)
    load(1, 0, 16'h0800, 13'd4, 16'h0, 13'd0);
    idle(3);
    send(8'hE1, 1, 16'h0800);
    send(8'hE2, 1, 16'h0801);
    idle(3);
    pulse_reset();
    idle(1);
    check("R9 status cleared", status, 0);
    check("R9 offset cleared", offset_a, 0);
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; in_data = 8'hF0 + 8'(k);
      @(negedge clk);
    end
    in_valid = 1'b0;
    pulse_reset();
    load(0, 1, 16'h0, 13'd0, 16'h0900, 13'd1);
    idle(3);
    send(8'hEE, 1, 16'h0900);
    idle(5);
    check("R9 FIFO and loss record emptied", status, 0);
    check("R2 scoreboard drained", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule